// File: doc/BRIEF.md
# Paired Event-State Page Controller

This block holds the two-bit pending/queued (PQ) state for a set of event queues and serves the memory-mapped pages through which software reads and changes that state. Every queue owns two adjacent pages. The lower page of the pair acts on the queue's notification PQ pair, and the upper page acts on its escalation PQ pair. Each access is a single 8-byte load or store. The address of the access selects the queue, the page and the operation.

A request is taken in one cycle. The PQ state is updated at the same clock edge, and the result appears one cycle later. A load always returns a 64-bit word: the pair value sits in the two least significant bits, which land in byte 7 in big-endian order. A store that asks for further delivery raises a one-cycle notify pulse. That pulse carries the queue index and a flag telling which of the two pairs fired. A per-queue enable input marks which queues exist.

Top module: `esb_pair_pages`

## Requirements
- R1: PAGE_SHIFT is 12 or 16, and any other value is rejected at elaboration. With a shift of 16, address bits 15:12 take no part in the operation decode.
- R2: The queue index is req_addr >> (PAGE_SHIFT+1). Bit PAGE_SHIFT selects the notification pair (0) or the escalation pair (1). The two pairs of a queue, and the pairs of different queues, change independently. A notify reports the index and pair of the access that caused it.
- R3: A store with offset bits [11:10]=00 is a trigger. It moves PQ 00 to 10 and raises notify. It moves 10 or 11 to 11 without notify. It leaves 01 unchanged.
- R4: A store with offset bits [11:10]=01 is an end-of-interrupt (EOI). It moves 10 to 00. It moves 11 to 10 and raises notify. It leaves 00 and 01 unchanged.
- R5: A load with offset bit 11 clear applies the EOI of R4 without a notify pulse. It returns 1 if the state was 11 and 0 otherwise.
- R6: A load with offset bits [11:10]=10 returns PQ as {62'b0,P,Q} and changes nothing.
- R7: A load with offset bits [11:10]=11 sets PQ to offset bits [9:8] and returns the old value.
- R8: A store with offset bits [11:10]=10 injects. On a notification page it raises notify and leaves PQ unchanged. On an escalation page it does nothing.
- R9: When the queue's enable bit is low, an access changes no state and raises no notify, and a load returns all ones.
- R10: A store with offset bits [11:10]=11 is undefined and changes no state and raises no notify.
- R11: rsp_valid and notify appear exactly one cycle after the request. rsp_valid follows loads only.
- R12: After reset, every PQ pair is 00 and rsp_valid and note_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | PAGE_SHIFT+1+QW | Byte address of the 8-byte access |
| q_valid | input | NUM_Q | Per-queue enable |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 64 | Load result |
| note_valid | output | 1 | Notify pulse |
| note_idx | output | QW | Queue that notified |
| note_esc | output | 1 | Notify came from the escalation pair |

## Verification
Each PQ pair is walked through all four states with triggers, store EOIs and load EOIs. Repeated triggers show that only the first edge notifies and later ones merely coalesce. Repeated EOIs tell a pending-with-queued state apart from a plain pending one. Set loads are used to reach each state directly, and their returned old value confirms the previous transition. Accesses to one pair are followed by reads of its sibling and of a neighbouring queue to expose crossed decode. Separate stimuli cover inject on both page kinds, disabled queues, undefined store offsets, and a 64 KB page configuration whose high in-page bits are not zero.

// File: rtl/esb_pair_pages.sv
module esb_pair_pages #(
  parameter int NUM_Q      = 16,
  parameter int PAGE_SHIFT = 12,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int AW = PAGE_SHIFT + 1 + QW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [NUM_Q-1:0] q_valid,
  output logic          rsp_valid,
  output logic [63:0]   rsp_data,
  output logic          note_valid,
  output logic [QW-1:0] note_idx,
  output logic          note_esc
);

  logic [1:0] pq_n [NUM_Q];
  logic [1:0] pq_e [NUM_Q];

  wire [QW-1:0] idx = req_addr[AW-1 -: QW];
  wire          esc = req_addr[PAGE_SHIFT];
  wire [11:0]   off = req_addr[11:0];
  wire          in_range = int'(idx) < NUM_Q;
  wire          live = req_valid && in_range && q_valid[idx];
  wire [1:0]    old = esc ? pq_e[idx] : pq_n[idx];

  logic [1:0]  nxt;
  logic        fire;
  logic [63:0] ldat;

  function automatic logic [2:0] trig(input logic [1:0] s);
    case (s)
      2'b00:   return 3'b110;
      2'b10,
      2'b11:   return 3'b011;
      default: return {1'b0, s};
    endcase
  endfunction

  function automatic logic [2:0] eoi(input logic [1:0] s);
    case (s)
      2'b10:   return 3'b000;
      2'b11:   return 3'b110;
      default: return {1'b0, s};
    endcase
  endfunction

  always_comb begin
    nxt  = old;
    fire = 1'b0;
    ldat = {62'b0, old};
    if (req_write) begin
      case (off[11:10])
        2'b00:   {fire, nxt} = trig(old);
        2'b01:   {fire, nxt} = eoi(old);
        2'b10:   fire = !esc;
        default: ;
      endcase
    end else if (!off[11]) begin
      nxt  = eoi(old)[1:0];
      ldat = {63'b0, eoi(old)[2]};
    end else if (off[10]) begin
      nxt = off[9:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_Q; i++) begin
        pq_n[i] <= 2'b00;
        pq_e[i] <= 2'b00;
      end
    end else if (live && nxt != old) begin
      if (esc) pq_e[idx] <= nxt;
      else     pq_n[idx] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      note_valid <= 1'b0;
      note_idx   <= '0;
      note_esc   <= 1'b0;
    end else begin
      rsp_valid  <= req_valid && !req_write;
      rsp_data   <= live ? ldat : '1;
      note_valid <= live && req_write && fire;
      note_idx   <= idx;
      note_esc   <= esc;
    end
  end

endmodule

module esb_pair_pages_chk #(
  parameter int NUM_Q      = 16,
  parameter int PAGE_SHIFT = 12,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int AW = PAGE_SHIFT + 1 + QW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [NUM_Q-1:0] q_valid,
  input logic          rsp_valid,
  input logic [63:0]   rsp_data,
  input logic          note_valid,
  input logic [QW-1:0] note_idx,
  input logic          note_esc
);

  wire [QW-1:0] c_idx = req_addr[AW-1 -: QW];
  wire          c_esc = req_addr[PAGE_SHIFT];
  wire [1:0]    c_op  = req_addr[11:10];
  wire          c_ok  = (int'(c_idx) < NUM_Q) && q_valid[c_idx];

  initial p_cfg_shift_r1: assert (PAGE_SHIFT == 12 || PAGE_SHIFT == 16);

  p_rsp_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_rsp_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_load_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> !note_valid);

  p_esc_inject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && c_esc && c_op == 2'b10) |=> !note_valid);

  p_undef_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && c_op == 2'b11) |=> !note_valid);

  p_dead_queue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !c_ok) |=> (!note_valid && (!rsp_valid || rsp_data == '1)));

  p_note_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid |-> (note_idx == $past(c_idx) && note_esc == $past(c_esc)));

endmodule

bind esb_pair_pages esb_pair_pages_chk #(.NUM_Q(NUM_Q), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .q_valid(q_valid), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .note_valid(note_valid), .note_idx(note_idx),
  .note_esc(note_esc)
);

// File: tb/esb_pair_pages_test.sv
`timescale 1ns/1ps
module esb_pair_pages_test;
  localparam int NQ = 16;
  localparam int AW = 12 + 1 + 4;
  localparam int WQ = 4;
  localparam int WAW = 16 + 1 + 2;

  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [NQ-1:0] q_valid = '1;
  logic          rsp_valid, note_valid, note_esc;
  logic [63:0]   rsp_data;
  logic [3:0]    note_idx;

  logic           w_valid = 0, w_write = 0;
  logic [WAW-1:0] w_addr = '0;
  logic           w_rsp_valid, w_note_valid, w_note_esc;
  logic [63:0]    w_rsp_data;
  logic [1:0]     w_note_idx;

  esb_pair_pages #(.NUM_Q(NQ), .PAGE_SHIFT(12)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .q_valid(q_valid), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .note_valid(note_valid), .note_idx(note_idx),
    .note_esc(note_esc));

  esb_pair_pages #(.NUM_Q(WQ), .PAGE_SHIFT(16)) uut_w (
    .clk(clk), .rst_n(rst_n), .req_valid(w_valid), .req_write(w_write),
    .req_addr(w_addr), .q_valid(4'hF), .rsp_valid(w_rsp_valid),
    .rsp_data(w_rsp_data), .note_valid(w_note_valid), .note_idx(w_note_idx),
    .note_esc(w_note_esc));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ld(input int q, input bit e, input logic [11:0] off, input logic [63:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = {4'(q), e, off};
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, {tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_data === exp, {tag, " data"}, rsp_data, exp);
    chk(note_valid === 1'b0, {tag, " no notify on load"}, 64'(note_valid), 64'd0);
  endtask

  task automatic st(input int q, input bit e, input logic [11:0] off, input bit exp_note, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = {4'(q), e, off};
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b0, {tag, " R11 no rsp on store"}, 64'(rsp_valid), 64'd0);
    chk(note_valid === exp_note, {tag, " notify"}, 64'(note_valid), 64'(exp_note));
    if (exp_note) begin
      chk(note_idx === 4'(q), {tag, " R2 note_idx"}, 64'(note_idx), 64'(q));
      chk(note_esc === e, {tag, " R2 note_esc"}, 64'(note_esc), 64'(e));
    end
  endtask

  task automatic t_reset;
    chk(rsp_valid === 1'b0 && note_valid === 1'b0, "R12 outputs low", {62'b0, rsp_valid, note_valid}, 0);
    ld(0, 0, 12'h800, 0, "R12 reset PQ n");
    ld(0, 1, 12'h800, 0, "R12 reset PQ e");
  endtask

  task automatic t_trigger;
    st(1, 0, 12'h000, 1, "R3 trig 00");
    ld(1, 0, 12'h800, 2, "R3 after first trig");
    st(1, 0, 12'h3F8, 0, "R3 trig 10");
    ld(1, 0, 12'h800, 3, "R3 coalesced");
    st(1, 0, 12'h010, 0, "R3 trig 11");
    ld(1, 0, 12'hD00, 3, "R7 set01 old");
    st(1, 0, 12'h000, 0, "R3 trig off");
    ld(1, 0, 12'h800, 1, "R3 off kept");
  endtask

  task automatic t_eoi;
    ld(2, 0, 12'hF00, 0, "R7 set11 old");
    st(2, 0, 12'h400, 1, "R4 eoi 11");
    ld(2, 0, 12'h800, 2, "R4 11->10");
    st(2, 0, 12'h7F8, 0, "R4 eoi 10");
    ld(2, 0, 12'h800, 0, "R4 10->00");
    st(2, 0, 12'h400, 0, "R4 eoi 00");
    ld(2, 0, 12'hE00, 0, "R7 set10 old");
    ld(2, 0, 12'hC00, 2, "R7 set00 old");
    ld(2, 0, 12'hBF8, 0, "R6 get after set");
  endtask

  task automatic t_load_eoi;
    ld(3, 0, 12'hF00, 0, "R7 set11");
    ld(3, 0, 12'h000, 1, "R5 load eoi 11");
    ld(3, 0, 12'h800, 2, "R5 now 10");
    ld(3, 0, 12'h7F8, 0, "R5 load eoi 10");
    ld(3, 0, 12'h800, 0, "R5 now 00");
  endtask

  task automatic t_pair;
    st(4, 1, 12'h000, 1, "R2 esc trig");
    ld(4, 1, 12'h800, 2, "R2 esc pair");
    ld(4, 0, 12'h800, 0, "R2 sibling untouched");
    ld(5, 1, 12'h800, 0, "R2 neighbour untouched");
  endtask

  task automatic t_inject;
    st(6, 0, 12'h800, 1, "R8 inject notif");
    ld(6, 0, 12'h800, 0, "R8 notif PQ kept");
    st(6, 1, 12'h800, 0, "R8 inject esc ignored");
    ld(6, 1, 12'h800, 0, "R8 esc PQ kept");
  endtask

  task automatic t_invalid;
    q_valid[7] = 0;
    st(7, 0, 12'h000, 0, "R9 trig dead queue");
    ld(7, 0, 12'h800, '1, "R9 load ones");
    ld(7, 1, 12'hF00, '1, "R9 set ones");
    q_valid[7] = 1;
    ld(7, 0, 12'h800, 0, "R9 notif unchanged");
    ld(7, 1, 12'h800, 0, "R9 esc unchanged");
  endtask

  task automatic t_undef;
    st(8, 0, 12'hC00, 0, "R10 undef store");
    ld(8, 0, 12'h800, 0, "R10 PQ unchanged");
  endtask

  task automatic t_wide;
    @(negedge clk);
    w_valid = 1; w_write = 1; w_addr = {2'd2, 1'b0, 4'hA, 12'h000};
    @(negedge clk);
    w_valid = 0;
    chk(w_note_valid === 1'b1 && w_note_idx === 2'd2 && w_note_esc === 1'b0,
        "R1 wide trig", {61'b0, w_note_valid, w_note_idx}, {61'b0, 1'b1, 2'd2});
    w_write = 0; w_addr = {2'd2, 1'b0, 4'h5, 12'h800}; w_valid = 1;
    @(negedge clk);
    w_valid = 0;
    chk(w_rsp_valid === 1'b1 && w_rsp_data === 64'd2, "R1 wide get", w_rsp_data, 64'd2);
    w_write = 1; w_addr = {2'd2, 1'b1, 4'hF, 12'h000}; w_valid = 1;
    @(negedge clk);
    w_valid = 0;
    chk(w_note_valid === 1'b1 && w_note_esc === 1'b1, "R1 wide esc trig",
        {62'b0, w_note_valid, w_note_esc}, 64'd3);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_trigger;
    t_eoi;
    t_load_eoi;
    t_pair;
    t_inject;
    t_invalid;
    t_undef;
    t_wide;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule